// File: doc/BRIEF.md
# Sliding-Window Running Sorter

This block keeps the most recent N pixels of a serial pixel stream as a list in ascending order. Each accepted pixel is placed straight into its sorted slot, and the pixel that has been resident for N accepts leaves in the same cycle. Every resident entry carries an age tag that counts the accepts it has seen, so the entry that leaves is found by its age and not by its position. This is not a FIFO: the entry that leaves can sit at any position in the list.

Each step has two stages and completes in one clock. First, N+1 insert cells, one of them a spare slot above the top, open a gap at the insertion point. Then a compaction stage closes the hole left by the retiring entry. A small controller tracks how full the window is, through the states `ST_EMPTY`, `ST_FILL` and `ST_FULL`. The transitions are: first accept (`ST_EMPTY`→`ST_FILL`, or straight to `ST_FULL` when N is 1), N-th accept (`ST_FILL`→`ST_FULL`), and reset (any state→`ST_EMPTY`). `ST_FULL` holds until reset. Downstream rank filters read the whole sorted vector, or the minimum, maximum and median taps.

Top module: `win_sorter`

## Requirements
- R1: While reset is asserted, and up to the first accept after it, `win_valid_o` is 0 and every sorted entry and every tap reads 0.
- R2: A pixel is accepted only on a rising clock edge where `in_valid` and `en` are both 1. Any other edge leaves the sorted vector, the taps and `win_valid_o` unchanged.
- R3: After k accepts with k < N, entries 0 to k-1 of `sorted_o` hold those k pixels in ascending order, and `win_valid_o` stays 0.
- R4: `win_valid_o` goes to 1 after the N-th accepted pixel and stays at 1 until reset.
- R5: Once the window is full, each accept drops the oldest resident pixel and inserts the new one. `sorted_o` then equals the last N accepted pixels sorted ascending, with entry i in bits [i*8 +: 8] and entry 0 the smallest.
- R6: `min_o` equals entry 0, `max_o` equals entry N-1 and `med_o` equals entry (N-1)/2 of the sorted vector.
- R7: Duplicate pixel values are each kept as separate entries. A new pixel is placed above equal entries, and retirement removes exactly one copy, the oldest.
- R8: The effect of an accept is visible on all outputs right after the clock edge that accepts it. There is no further pipeline delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Global update enable |
| in_valid | input | 1 | Pixel on `in_pix` is offered this cycle |
| in_pix | input | PW (8) | Incoming pixel value |
| sorted_o | output | N*PW (72) | Sorted window, entry i at bits [i*PW +: PW] |
| min_o | output | PW (8) | Smallest resident pixel |
| max_o | output | PW (8) | Largest resident pixel |
| med_o | output | PW (8) | Median resident pixel |
| win_valid_o | output | 1 | Window holds N pixels |

## Verification
The hardest case to reach is retirement of the oldest entry while copies of its value sit in the list around it, or while it sits at the far top or bottom of the list. Only the per-cell age tags pick out which copy leaves. The stimulus reaches this with runs of repeated values mixed with single lower values, and with strictly rising and then falling ramps, so that the oldest entry ends up at each end of the list. A long pseudo-random stream with idle and disabled cycles between accepts then checks the vector against a reference that sorts the last N accepted pixels.

// File: rtl/wsort_pkg.sv
package wsort_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FILL  = 2'd1,
        ST_FULL  = 2'd2
    } wsort_state_e;

    function automatic int age_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/wsort_insert_cell.sv
// One insert slot: keeps its entry, takes the new pixel, or takes the entry below.
module wsort_insert_cell #(
    parameter int PW = 8,
    parameter int AW = 4
) (
    input  logic          is_bottom,
    input  logic [PW-1:0] pix,
    input  logic          self_occ,
    input  logic [PW-1:0] self_val,
    input  logic [AW-1:0] self_age,
    input  logic          self_ret,
    input  logic          low_occ,
    input  logic [PW-1:0] low_val,
    input  logic [AW-1:0] low_age,
    input  logic          low_ret,
    output logic          o_occ,
    output logic [PW-1:0] o_val,
    output logic [AW-1:0] o_age,
    output logic          o_ret
);
    logic stay;
    logic low_stays;

    always_comb begin
        // equal entries stay below the newcomer
        stay      = self_occ && (pix >= self_val);
        low_stays = is_bottom || (low_occ && (pix >= low_val));
        if (stay) begin
            o_occ = 1'b1;
            o_val = self_val;
            o_age = self_age + AW'(1);
            o_ret = self_ret;
        end else if (low_stays) begin
            o_occ = 1'b1;
            o_val = pix;
            o_age = '0;
            o_ret = 1'b0;
        end else begin
            o_occ = low_occ;
            o_val = low_val;
            o_age = low_age + AW'(1);
            o_ret = low_ret;
        end
    end
endmodule

// File: rtl/wsort_compact.sv
// Closes the hole left by the retiring entry: slots at or above it take the slot above.
module wsort_compact #(
    parameter int N  = 9,
    parameter int PW = 8,
    parameter int AW = 4
) (
    input  logic [N:0]          ext_occ,
    input  logic [N:0][PW-1:0]  ext_val,
    input  logic [N:0][AW-1:0]  ext_age,
    input  logic [N:0]          ext_ret,
    output logic [N-1:0]        c_occ,
    output logic [N-1:0][PW-1:0] c_val,
    output logic [N-1:0][AW-1:0] c_age,
    output logic                dropped
);
    logic [N:0] gone;

    assign gone[0] = ext_ret[0];
    for (genvar g = 1; g <= N; g++) begin : g_prefix
        assign gone[g] = gone[g-1] | ext_ret[g];
    end
    assign dropped = gone[N];

    for (genvar n = 0; n < N; n++) begin : g_slot
        assign c_occ[n] = gone[n] ? ext_occ[n+1] : ext_occ[n];
        assign c_val[n] = gone[n] ? ext_val[n+1] : ext_val[n];
        assign c_age[n] = gone[n] ? ext_age[n+1] : ext_age[n];
    end
endmodule

// File: rtl/win_sorter.sv
module win_sorter #(
    parameter int N  = 9,
    parameter int PW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            in_valid,
    input  logic [PW-1:0]   in_pix,
    output logic [N*PW-1:0] sorted_o,
    output logic [PW-1:0]   min_o,
    output logic [PW-1:0]   max_o,
    output logic [PW-1:0]   med_o,
    output logic            win_valid_o
);
    import wsort_pkg::*;

    localparam int AW   = age_width(N);
    localparam int CW   = $clog2(N + 1);
    localparam int MIDX = (N - 1) / 2;

    wsort_state_e state_q, state_d;
    logic [CW-1:0] fill_q;

    logic [N-1:0]         occ_q;
    logic [N-1:0][PW-1:0] val_q;
    logic [N-1:0][AW-1:0] age_q;
    logic [N-1:0]         ret_now;

    logic [N:0]          ext_occ;
    logic [N:0][PW-1:0]  ext_val;
    logic [N:0][AW-1:0]  ext_age;
    logic [N:0]          ext_ret;

    logic [N-1:0]         nxt_occ;
    logic [N-1:0][PW-1:0] nxt_val;
    logic [N-1:0][AW-1:0] nxt_age;
    logic                 dropped;

    logic accept;
    assign accept = en && in_valid;

    for (genvar n = 0; n < N; n++) begin : g_ret
        assign ret_now[n] = occ_q[n] && (age_q[n] == AW'(N - 1));
    end

    // insert stage: N slots plus one overflow slot above the top
    for (genvar n = 0; n <= N; n++) begin : g_ins
        if (n == 0) begin : g_bot
            wsort_insert_cell #(.PW(PW), .AW(AW)) u_cell (
                .is_bottom (1'b1),     .pix      (in_pix),
                .self_occ  (occ_q[0]), .self_val (val_q[0]),
                .self_age  (age_q[0]), .self_ret (ret_now[0]),
                .low_occ   (1'b0),     .low_val  ('0),
                .low_age   ('0),       .low_ret  (1'b0),
                .o_occ     (ext_occ[0]), .o_val  (ext_val[0]),
                .o_age     (ext_age[0]), .o_ret  (ext_ret[0])
            );
        end else if (n == N) begin : g_ovf
            wsort_insert_cell #(.PW(PW), .AW(AW)) u_cell (
                .is_bottom (1'b0),       .pix      (in_pix),
                .self_occ  (1'b0),       .self_val ('0),
                .self_age  ('0),         .self_ret (1'b0),
                .low_occ   (occ_q[n-1]), .low_val  (val_q[n-1]),
                .low_age   (age_q[n-1]), .low_ret  (ret_now[n-1]),
                .o_occ     (ext_occ[n]), .o_val    (ext_val[n]),
                .o_age     (ext_age[n]), .o_ret    (ext_ret[n])
            );
        end else begin : g_mid
            wsort_insert_cell #(.PW(PW), .AW(AW)) u_cell (
                .is_bottom (1'b0),       .pix      (in_pix),
                .self_occ  (occ_q[n]),   .self_val (val_q[n]),
                .self_age  (age_q[n]),   .self_ret (ret_now[n]),
                .low_occ   (occ_q[n-1]), .low_val  (val_q[n-1]),
                .low_age   (age_q[n-1]), .low_ret  (ret_now[n-1]),
                .o_occ     (ext_occ[n]), .o_val    (ext_val[n]),
                .o_age     (ext_age[n]), .o_ret    (ext_ret[n])
            );
        end
    end

    wsort_compact #(.N(N), .PW(PW), .AW(AW)) u_compact (
        .ext_occ (ext_occ), .ext_val (ext_val),
        .ext_age (ext_age), .ext_ret (ext_ret),
        .c_occ   (nxt_occ), .c_val   (nxt_val),
        .c_age   (nxt_age), .dropped (dropped)
    );

    // fill controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept && !dropped)
                fill_q <= fill_q + CW'(1);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = (N == 1) ? ST_FULL : ST_FILL;
            ST_FILL:  if (accept && (fill_q == CW'(N - 1))) state_d = ST_FULL;
            ST_FULL:  state_d = ST_FULL;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // cell array
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q <= '0;
            val_q <= '0;
            age_q <= '0;
        end else if (accept) begin
            occ_q <= nxt_occ;
            val_q <= nxt_val;
            age_q <= nxt_age;
        end
    end

    // outputs
    always_comb begin
        win_valid_o = (state_q == ST_FULL);
        for (int i = 0; i < N; i++)
            sorted_o[i*PW +: PW] = val_q[i];
        min_o = val_q[0];
        max_o = val_q[N-1];
        med_o = val_q[MIDX];
    end
endmodule

// File: rtl/win_sorter_checker.sv
module win_sorter_checker #(
    parameter int N  = 9,
    parameter int PW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic            in_valid,
    input logic [PW-1:0]   in_pix,
    input logic [N*PW-1:0] sorted_o,
    input logic [PW-1:0]   min_o,
    input logic [PW-1:0]   max_o,
    input logic [PW-1:0]   med_o,
    input logic            win_valid_o
);
    logic ordered;
    logic [PW-1:0] pix_d;
    logic has_pix;

    always_ff @(posedge clk) pix_d <= in_pix;

    always_comb begin
        ordered = 1'b1;
        has_pix = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (sorted_o[i*PW +: PW] == pix_d) has_pix = 1'b1;
            if (i > 0 && sorted_o[i*PW +: PW] < sorted_o[(i-1)*PW +: PW]) ordered = 1'b0;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> !win_valid_o);

    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && in_valid) |=> $stable(sorted_o) && $stable(win_valid_o));

    a_r4_valid_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o |=> win_valid_o);

    a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o |-> ordered);

    a_r5_new_pixel_present: assert property (@(posedge clk) disable iff (!rst_n)
        (en && in_valid) |=> has_pix);

    a_r6_taps_bracket: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o |-> (min_o <= med_o) && (med_o <= max_o));
endmodule

bind win_sorter win_sorter_checker #(.N(N), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid), .in_pix(in_pix),
    .sorted_o(sorted_o), .min_o(min_o), .max_o(max_o), .med_o(med_o),
    .win_valid_o(win_valid_o)
);

// File: tb/win_sorter_bench.sv
module win_sorter_bench;
    localparam int N = 9;
    localparam int PW = 8;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int cnt;
        int vals[N];
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic in_valid = 1'b0;
    logic [PW-1:0] in_pix = '0;
    logic [N*PW-1:0] sorted_o;
    logic [PW-1:0] min_o, max_o, med_o;
    logic win_valid_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    exp_t exp_q[$];
    int hist[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    win_sorter #(.N(N), .PW(PW)) u_win_sorter (
        .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid), .in_pix(in_pix),
        .sorted_o(sorted_o), .min_o(min_o), .max_o(max_o), .med_o(med_o),
        .win_valid_o(win_valid_o)
    );

    task automatic drive(input int p, input bit v, input bit e, input string tag);
        exp_t it;
        int srt[$];
        @(negedge clk);
        in_pix = PW'(p); in_valid = v; en = e;
        @(posedge clk);
        #1;
        if (v && e) begin
            hist.push_back(p);
            if (hist.size() > N) void'(hist.pop_front());
        end
        srt = hist;
        srt.sort();
        it.cnt = srt.size();
        for (int i = 0; i < N; i++) it.vals[i] = (i < srt.size()) ? srt[i] : 0;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    // monitor: compares one expected item per cycle, one edge after it was driven
    exp_t cur;
    bit bad;
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            bad = 0;
            checks++;
            if (win_valid_o !== (cur.cnt == N)) begin
                bad = 1;
                $display("FAIL %s win_valid actual=%0b expected=%0b", cur.tag, win_valid_o, cur.cnt == N);
            end
            for (int i = 0; i < cur.cnt; i++)
                if (sorted_o[i*PW +: PW] !== PW'(cur.vals[i])) begin
                    bad = 1;
                    $display("FAIL %s entry %0d actual=%0d expected=%0d", cur.tag, i, sorted_o[i*PW +: PW], cur.vals[i]);
                end
            if (cur.cnt == N) begin
                if (min_o !== PW'(cur.vals[0]) || max_o !== PW'(cur.vals[N-1]) || med_o !== PW'(cur.vals[(N-1)/2])) begin
                    bad = 1;
                    $display("FAIL R6 %s taps actual=%0d/%0d/%0d expected=%0d/%0d/%0d", cur.tag,
                             min_o, med_o, max_o, cur.vals[0], cur.vals[(N-1)/2], cur.vals[N-1]);
                end
            end
            if (bad) fails++;
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        // R1: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (win_valid_o !== 1'b0 || sorted_o !== '0 || min_o !== '0 || max_o !== '0 || med_o !== '0) begin
            fails++;
            $display("FAIL R1 reset outputs actual=%0h valid=%0b expected=0 valid=0", sorted_o, win_valid_o);
        end
        @(negedge clk) rst_n = 1'b1;
        drive(33, 1'b1, 1'b0, "R1");        // enable low: still empty
        checks++;
        if (sorted_o !== '0 || win_valid_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 post-reset actual=%0h expected=0", sorted_o);
        end
        // R3 / R4 / R8: fill with falling values
        for (int k = 0; k < N - 1; k++) drive(90 - 10 * k, 1'b1, 1'b1, "R3");
        drive(5, 1'b1, 1'b1, "R4 R8");
        // R2: idle and disabled cycles
        drive(200, 1'b1, 1'b0, "R2");
        drive(201, 1'b0, 1'b1, "R2");
        drive(202, 1'b0, 1'b0, "R2");
        // R5: rising ramp pushes out every old entry, oldest at varying positions
        for (int k = 0; k < N; k++) drive(100 + 3 * k, 1'b1, 1'b1, "R5");
        for (int k = 0; k < N; k++) drive(250 - 7 * k, 1'b1, 1'b1, "R5");
        // R6: extremes
        drive(0, 1'b1, 1'b1, "R6");
        drive(255, 1'b1, 1'b1, "R6");
        // R7: duplicates
        for (int k = 0; k < 3 * N; k++) drive((k % 4 == 3) ? 3 : 7, 1'b1, 1'b1, "R7");
        for (int k = 0; k < N; k++) drive(7, 1'b1, 1'b1, "R7");
        drive(7, 1'b0, 1'b1, "R2");
        // R5 / R6: pseudo-random stream with gaps
        lfsr = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr[7:0] & ((k % 50 < 25) ? 8'hFF : 8'h0F), lfsr[9] | lfsr[11], ~(lfsr[8] & lfsr[10]), "R5");
        end
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule